// File: doc/BRIEF.md
# Eight-Bit Arithmetic/Logic Unit with Status Flags

This block is the execute stage of a small 8-bit load-store core. Each accepted instruction supplies the destination value, a second register value or an 8-bit immediate, a destination index and an operation code. One clock edge later the unit presents a single register write-back (index, data, enable) and an updated six-bit status register. The register file, fetch and memory sit outside it.

Each operation has its own rule for which status bits it touches. Compares update flags but never write back. Move and load-immediate write back but leave the flags alone. The carry-chaining add and subtract fold the incoming carry into the sum and can only clear the zero flag, so a chain of byte operations yields a correct multi-byte zero test. The unsigned multiply writes its 16-bit product to the fixed pair r1:r0 over two consecutive cycles. During the second of those cycles the unit is busy and turns away new work.

Top module: `alu8_core`

## Requirements
- R1: sreg_o holds C at bit 0, Z at bit 1, N at bit 2, V at bit 3, S at bit 4 and H at bit 5. After reset sreg_o is zero, wr_en_o is low and ready_o is high.
- R2: add and add-with-carry return (Rd + Rr + cin) mod 256, with cin = C for add-with-carry and 0 otherwise. C is the carry out of bit 7 and H the carry out of bit 3. V is set when both operands share a sign and the result's sign differs. N is result bit 7 and S = N xor V.
- R3: subtract and subtract-with-carry return (Rd - Rr - cin) mod 256, with cin = C for subtract-with-carry. C is set when Rr + cin exceeds Rd as unsigned values, and H is the borrow out of bit 3. V is set when the operand signs differ and the result's sign differs from Rd. N is result bit 7 and S = N xor V.
- R4: for add-with-carry and subtract-with-carry, the new Z is the old Z AND (result == 0). For every other arithmetic or logic operation, Z is simply (result == 0).
- R5: register compare and compare-with-immediate set the flags exactly as subtract does. They never assert wr_en_o.
- R6: load-immediate and compare-with-immediate take imm_i as the operand. Load-immediate writes imm_i to register 16 + rd_idx_i[3:0].
- R7: AND, OR and XOR write the bitwise result. They clear V, set N and Z from the result and set S = N. C and H keep their values.
- R8: complement writes 255 - Rd, sets C, clears V, sets N, Z and S = N, and keeps H. Negate writes (0 - Rd) mod 256, with flags as a subtract of Rd from zero.
- R9: register move writes Rr and load-immediate writes imm_i. Neither changes sreg_o.
- R10: multiply forms the unsigned product P = Rd * Rr. On the first output cycle it writes P[7:0] to index 0 and drops ready_o. On the next cycle it writes P[15:8] to index 1. Z = (P == 0) and C = P[15], and the other flags are kept.
- R11: while ready_o is low, valid_i is ignored: no write-back for it and no flag change.
- R12: an instruction accepted at a rising edge shows its write-back from that edge for exactly one cycle (multiply for two). With no accepted instruction, wr_en_o is low. Register-operand instructions write to rd_idx_i.
- R13: op_i encodings are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 compare, 5 compare-with-immediate, 6 AND, 7 OR, 8 XOR, 9 complement, 10 negate, 11 move, 12 load-immediate, 13 multiply. Codes 14 and 15 write nothing and leave sreg_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| op_i | input | 4 | Operation code |
| rd_idx_i | input | 5 | Destination register index |
| rd_val_i | input | 8 | Destination register value (first operand) |
| rr_val_i | input | 8 | Source register value |
| imm_i | input | 8 | Immediate operand |
| ready_o | output | 1 | Unit can accept an instruction |
| wr_en_o | output | 1 | Write-back enable |
| wr_idx_o | output | 5 | Write-back register index |
| wr_data_o | output | 8 | Write-back data |
| sreg_o | output | 6 | Status register |

## Verification
The high-byte write of a multiply and the arrival of a new instruction can fall in the same cycle. After every multiply in the sweep, the bench asserts valid_i on the very next cycle with an add whose operands would change every flag. The bench then requires that this cycle's write-back is the product's high byte to index 1, that sreg_o keeps the value the multiply left, and that ready_o returns high. The operand sweeps also place a flag-setting compare just before each carry-chained operation, so that both values of the incoming carry and zero reach the sticky-zero logic.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 5;
  localparam int NIB_W  = 4;
  localparam int FLAG_W = 6;
  localparam int OP_W   = 4;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_CP  = 4'd4,  OP_CPI = 4'd5,  OP_AND = 4'd6,  OP_OR  = 4'd7,
    OP_EOR = 4'd8,  OP_COM = 4'd9,  OP_NEG = 4'd10, OP_MOV = 4'd11,
    OP_LDI = 4'd12, OP_MUL = 4'd13, OP_R14 = 4'd14, OP_R15 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2, LG_INV = 2'd3
  } logic_sel_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W  = 8,
  parameter int HB = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         h_o,
  output logic         v_o
);
  localparam int FW = W + 1;
  localparam int NW = HB + 1;

  logic [FW-1:0] full;
  logic [NW-1:0] nib;

  always_comb begin
    if (sub_i) begin
      full = {1'b0, x_i} - {1'b0, y_i} - FW'(cin_i);
      nib  = {1'b0, x_i[HB-1:0]} - {1'b0, y_i[HB-1:0]} - NW'(cin_i);
    end else begin
      full = {1'b0, x_i} + {1'b0, y_i} + FW'(cin_i);
      nib  = {1'b0, x_i[HB-1:0]} + {1'b0, y_i[HB-1:0]} + NW'(cin_i);
    end
    res_o = full[W-1:0];
    c_o   = full[W];   // carry on add, borrow on subtract
    h_o   = nib[HB];
    if (sub_i)
      v_o = (x_i[W-1] != y_i[W-1]) && (res_o[W-1] != x_i[W-1]);
    else
      v_o = (x_i[W-1] == y_i[W-1]) && (res_o[W-1] != x_i[W-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  assign prod_o = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W,
  parameter int FW = FLAG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [IW-1:0] rd_idx_i,
  input  logic [DW-1:0] rd_val_i,
  input  logic [DW-1:0] rr_val_i,
  input  logic [DW-1:0] imm_i,
  output logic          ready_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [DW-1:0] wr_data_o,
  output logic [FW-1:0] sreg_o
);
  localparam int PW = 2 * DW;
  localparam logic [IW-1:0] PAIR_LO = IW'(0);
  localparam logic [IW-1:0] PAIR_HI = IW'(1);

  alu_op_e       op;
  logic          imm_op, chain_op;
  logic [DW-1:0] opnd;
  logic [DW-1:0] as_x, as_y, as_res;
  logic          as_sub, as_cin, as_c, as_h, as_v;
  logic_sel_e    lg_sel;
  logic [DW-1:0] lg_res;
  logic [PW-1:0] prod;

  logic [FW-1:0] sreg_q, sreg_d;
  logic          we_q, we_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] data_q, data_d;
  logic [DW-1:0] hi_q;
  logic          busy_q;

  assign op       = alu_op_e'(op_i);
  assign imm_op   = (op == OP_LDI) || (op == OP_CPI);
  assign chain_op = (op == OP_ADC) || (op == OP_SBC);
  assign opnd     = imm_op ? imm_i : rr_val_i;

  always_comb begin
    as_x   = (op == OP_NEG) ? '0 : rd_val_i;
    as_y   = (op == OP_NEG) ? rd_val_i : opnd;
    as_sub = op inside {OP_SUB, OP_SBC, OP_CP, OP_CPI, OP_NEG};
    as_cin = chain_op & sreg_q[FLG_C];
    unique case (op)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      OP_EOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_INV;
    endcase
  end

  alu8_addsub #(.W(DW), .HB(NIB_W)) u_addsub (
    .x_i(as_x), .y_i(as_y), .cin_i(as_cin), .sub_i(as_sub),
    .res_o(as_res), .c_o(as_c), .h_o(as_h), .v_o(as_v)
  );

  alu8_logic #(.W(DW)) u_logic (
    .a_i(rd_val_i), .b_i(rr_val_i), .sel_i(lg_sel), .res_o(lg_res)
  );

  alu8_mul #(.W(DW)) u_mul (
    .a_i(rd_val_i), .b_i(rr_val_i), .prod_o(prod)
  );

  always_comb begin
    sreg_d = sreg_q;
    we_d   = 1'b1;
    idx_d  = imm_op ? {1'b1, rd_idx_i[IW-2:0]} : rd_idx_i;
    data_d = '0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPI, OP_NEG: begin
        data_d        = as_res;
        we_d          = !(op inside {OP_CP, OP_CPI});
        sreg_d[FLG_C] = as_c;
        sreg_d[FLG_H] = as_h;
        sreg_d[FLG_V] = as_v;
        sreg_d[FLG_N] = as_res[DW-1];
        sreg_d[FLG_S] = as_res[DW-1] ^ as_v;
        // chained ops may only clear Z so multi-byte zero tests hold
        sreg_d[FLG_Z] = (as_res == '0) & (!chain_op | sreg_q[FLG_Z]);
      end
      OP_AND, OP_OR, OP_EOR, OP_COM: begin
        data_d        = lg_res;
        sreg_d[FLG_V] = 1'b0;
        sreg_d[FLG_N] = lg_res[DW-1];
        sreg_d[FLG_S] = lg_res[DW-1];
        sreg_d[FLG_Z] = (lg_res == '0);
        if (op == OP_COM) sreg_d[FLG_C] = 1'b1;
      end
      OP_MOV: data_d = rr_val_i;
      OP_LDI: data_d = imm_i;
      OP_MUL: begin
        data_d        = prod[DW-1:0];
        idx_d         = PAIR_LO;
        sreg_d[FLG_Z] = (prod == '0);
        sreg_d[FLG_C] = prod[PW-1];
      end
      default: we_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      we_q   <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
      hi_q   <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      we_q   <= 1'b1;
      idx_q  <= PAIR_HI;
      data_q <= hi_q;
      busy_q <= 1'b0;
    end else if (valid_i) begin
      sreg_q <= sreg_d;
      we_q   <= we_d;
      idx_q  <= idx_d;
      data_q <= data_d;
      hi_q   <= prod[PW-1:DW];
      busy_q <= (op == OP_MUL);
    end else begin
      we_q   <= 1'b0;
    end
  end

  assign ready_o   = !busy_q;
  assign wr_en_o   = we_q;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = data_q;
  assign sreg_o    = sreg_q;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [3:0]          op_i,
  input logic [IDX_W-1:0]    rd_idx_i,
  input logic [DATA_W-1:0]   rd_val_i,
  input logic [DATA_W-1:0]   rr_val_i,
  input logic [DATA_W-1:0]   imm_i,
  input logic                ready_o,
  input logic                wr_en_o,
  input logic [IDX_W-1:0]    wr_idx_o,
  input logic [DATA_W-1:0]   wr_data_o,
  input logic [FLAG_W-1:0]   sreg_o
);
  logic take;
  assign take = valid_i && ready_o;

  a_r5_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (op_i == OP_CP || op_i == OP_CPI) |=> !wr_en_o);

  a_r9_move_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (op_i == OP_MOV || op_i == OP_LDI) |=> $stable(sreg_o));

  a_r6_ldi_upper_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && op_i == OP_LDI |=> wr_en_o && wr_idx_o[IDX_W-1]);

  a_r10_mul_low_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && op_i == OP_MUL |=> wr_en_o && wr_idx_o == '0 && !ready_o);

  a_r10_mul_high_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> wr_en_o && wr_idx_o == IDX_W'(1) && ready_o);

  a_r11_busy_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(sreg_o));

  a_r4_chain_z_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (op_i == OP_ADC || op_i == OP_SBC) && !sreg_o[FLG_Z] |=> !sreg_o[FLG_Z]);

  a_r13_undef_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && op_i >= 4'd14 |=> !wr_en_o && $stable(sreg_o));

  a_r12_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && ready_o |=> !wr_en_o);
endmodule

bind alu8_core alu8_core_chk chk_i (.*);

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       valid;
  logic [3:0] op;
  logic [4:0] rd_idx;
  logic [7:0] rd_val, rr_val, imm;
  logic       ready, wr_en;
  logic [4:0] wr_idx;
  logic [7:0] wr_data;
  logic [5:0] sreg;

  int   errs = 0;
  int   checks = 0;
  bit   done = 0;
  logic [5:0] msreg;

  always #4 clk = ~clk;

  alu8_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .rd_idx_i(rd_idx), .rd_val_i(rd_val), .rr_val_i(rr_val), .imm_i(imm),
    .ready_o(ready), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .sreg_o(sreg)
  );

  function automatic logic [20:0] pack_act();
    return {ready, wr_en, wr_en ? wr_idx : 5'd0, wr_en ? wr_data : 8'd0, sreg};
  endfunction

  task automatic chk(string tag, logic [20:0] act, logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int o);
    case (o)
      0, 1:       return "R2";
      2, 3:       return "R3";
      4:          return "R5";
      5, 12:      return "R6";
      6, 7, 8:    return "R7";
      9, 10:      return "R8";
      11:         return "R9";
      13:         return "R10";
      default:    return "R13";
    endcase
  endfunction

  // reference model from the requirements; updates msreg
  task automatic model(input int o, input logic [4:0] rd, input int a, input int b,
                       input int im, output bit we, output logic [4:0] idx,
                       output logic [7:0] data, output logic [7:0] hi);
    int ci, r, full, x, y, p;
    bit c, h, v, n, z;
    we = 1; idx = rd; hi = 0; r = 0;
    case (o)
      0, 1: begin
        ci = (o == 1) ? int'(msreg[0]) : 0;
        full = a + b + ci; r = full & 255;
        c = full > 255; h = ((a & 15) + (b & 15) + ci) > 15;
        v = ((a >= 128) == (b >= 128)) && ((r >= 128) != (a >= 128));
        n = r >= 128;
        z = (o == 1) ? (r == 0 && msreg[1]) : (r == 0);
        msreg = {h, n ^ v, v, n, z, c};
      end
      2, 3, 4, 5, 10: begin
        x = (o == 10) ? 0 : a;
        y = (o == 10) ? a : ((o == 5) ? im : b);
        ci = (o == 3) ? int'(msreg[0]) : 0;
        full = x - y - ci; r = full & 255;
        c = full < 0; h = ((x & 15) - (y & 15) - ci) < 0;
        v = ((x >= 128) != (y >= 128)) && ((r >= 128) != (x >= 128));
        n = r >= 128;
        z = (o == 3) ? (r == 0 && msreg[1]) : (r == 0);
        msreg = {h, n ^ v, v, n, z, c};
        if (o == 4 || o == 5) we = 0;
      end
      6, 7, 8, 9: begin
        r = (o == 6) ? (a & b) : (o == 7) ? (a | b) : (o == 8) ? (a ^ b) : (255 - a);
        n = r >= 128;
        msreg[4] = n; msreg[3] = 0; msreg[2] = n; msreg[1] = (r == 0);
        if (o == 9) msreg[0] = 1;
      end
      11: r = b;
      12: begin r = im; idx = {1'b1, rd[3:0]}; end
      13: begin
        p = a * b; r = p & 255; hi = 8'(p >> 8); idx = 5'd0;
        msreg[1] = (p == 0); msreg[0] = (p >= 32768);
      end
      default: we = 0;
    endcase
    data = 8'(r);
  endtask

  task automatic run(int o, logic [4:0] rd, int a, int b, int im, string tag);
    bit we; logic [4:0] idx; logic [7:0] d, hi;
    valid = 1; op = o[3:0]; rd_idx = rd;
    rd_val = a[7:0]; rr_val = b[7:0]; imm = im[7:0];
    model(o, rd, a, b, im, we, idx, d, hi);
    @(negedge clk);
    chk(tag, pack_act(), {(o == 13) ? 1'b0 : 1'b1, we, we ? idx : 5'd0, we ? d : 8'd0, msreg});
    if (o == 13) begin
      // R11: a flag-changing add arrives during the high-byte cycle
      valid = 1; op = 4'd0; rd_idx = 5'd7; rd_val = 8'h80; rr_val = 8'h80;
      @(negedge clk);
      chk("R11", pack_act(), {1'b1, 1'b1, 5'd1, hi, msreg});
    end
    valid = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; valid = 0; op = 0; rd_idx = 0; rd_val = 0; rr_val = 0; imm = 0;
    msreg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", pack_act(), {1'b1, 1'b0, 5'd0, 8'd0, 6'd0});

    // R4 directed: sticky zero across chained ops
    run(0, 5'd2, 0, 0, 0, "R2");
    run(1, 5'd3, 0, 0, 0, "R4");
    run(1, 5'd3, 1, 0, 0, "R4");
    run(1, 5'd3, 255, 1, 0, "R4");
    run(4, 5'd4, 9, 9, 0, "R5");
    run(3, 5'd5, 3, 3, 0, "R4");
    run(3, 5'd5, 4, 3, 0, "R4");
    // R6 directed: load-immediate target in upper half
    run(12, 5'd3, 0, 0, 8'h42, "R6");
    // R12: idle cycle writes nothing
    @(negedge clk);
    chk("R12", pack_act(), {1'b1, 1'b0, 5'd0, 8'd0, msreg});
    run(10, 5'd9, 8'h80, 0, 0, "R8");
    run(13, 5'd9, 0, 77, 0, "R10");
    run(13, 5'd9, 255, 255, 0, "R10");

    for (int o = 0; o < 16; o++) begin
      for (int a = 0; a < 256; a += 3) begin
        for (int b = 0; b < 256; b += 5) begin
          logic [4:0] rd;
          rd = 5'((a * 7 + b) & 31);
          if (o == 1 || o == 3) begin
            if ((b & 1) == 1) run(4, rd, a, a, 0, "R5");
            else              run(5, rd, 0, 0, 1, "R6");
          end
          run(o, rd, a, b, b ^ 8'h5a, tag_of(o));
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule